// File: doc/BRIEF.md
# Processor sleep and event controller

This block sits next to a small processor core and decides when the core may execute, when its clocks are gated, and when the PLL and flash are asked to power down. The core reports three instructions as single-cycle pulses: wait-for-interrupt, wait-for-event and send-event. From these, and from an external event line, a pending-interrupt line, a debug request and a deep-sleep select bit, the block drives clock enables, power-down requests and a stall to the core.

A hidden one-bit event latch decides whether a wait-for-event actually sleeps. Send-event pulses and the external event line set the latch. A wait-for-event clears it and does not sleep if the latch was set. The deep-sleep select bit, captured at the moment of entry, chooses between a light sleep that gates only the core clock and a deep sleep that gates the system clock and powers down the PLL and flash. When the block leaves deep sleep, it releases the power-down requests for a set number of cycles before it restores the system clock.

Top module: `slp_evt_ctrl`

## Requirements
- R1: After reset the outputs show the running state (core_clk_en=1, sys_clk_en=1, pll_pd_req=0, flash_pd_req=0, core_stall=0) and the event latch is clear, so a wait-for-event right after reset sleeps. An asynchronous reset in the middle of a sleep returns the block to this state at once.
- R2: A wait-for-interrupt pulse taken while running enters sleep on the next cycle, whatever the event latch holds.
- R3: A wait-for-event pulse with the event latch clear and no event arriving in the same cycle enters sleep on the next cycle.
- R4: A wait-for-event pulse with the event latch set keeps the core running and clears the latch, so the next wait-for-event sleeps.
- R5: A send-event pulse or an asserted external event sets the event latch. Software has no other path to the latch.
- R6: Sleep entered with deep_sel=0 gives core_clk_en=0, core_stall=1, sys_clk_en=1 and no power-down requests.
- R7: Sleep entered with deep_sel=1 gives core_clk_en=0, sys_clk_en=0, pll_pd_req=1, flash_pd_req=1 and core_stall=1.
- R8: deep_sel is sampled only when sleep is entered. Changing it during sleep has no effect on the outputs.
- R9: irq_pend or dbg_req wakes the core from either sleep. A light sleep returns to running on the next cycle, and sleep can be entered again at once.
- R10: On a wake from deep sleep, the power-down requests drop for WAKE_GAP cycles (default 1) while sys_clk_en stays 0 and the core stays stalled. Only then are the clocks restored.
- R11: An event (send-event or external) wakes a sleep that was entered by wait-for-event and leaves the latch clear. During a sleep entered by wait-for-interrupt, an event does not wake the core but sets the latch.
- R12: When wait-for-event and send-event arrive in the same cycle, the send-event is applied first: the core does not sleep and the latch ends clear.
- R13: Instruction pulses that arrive while the core is asleep are ignored. A wait-for-event pulse during a wait-for-interrupt sleep neither wakes the core nor changes its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_pulse | input | 1 | Core executed wait-for-interrupt (one cycle) |
| wfe_pulse | input | 1 | Core executed wait-for-event (one cycle) |
| sev_pulse | input | 1 | Core executed send-event (one cycle) |
| ext_evt | input | 1 | External event input |
| irq_pend | input | 1 | An interrupt is pending |
| dbg_req | input | 1 | Debug request, wakes the core |
| deep_sel | input | 1 | Deep-sleep select bit from the control register |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| pll_pd_req | output | 1 | PLL power-down request |
| flash_pd_req | output | 1 | Flash power-down request |
| core_stall | output | 1 | Holds the core while it is not running |

## Verification
The hardest situation to reach is the event latch holding a value that came in while the core was asleep. The latch has no read path, so it shows only through what the next wait-for-event does. The stimulus sets the latch with a send-event during a wait-for-interrupt deep sleep, wakes the core, then issues a wait-for-event and expects it to fall through. A second wait-for-event, issued after an external event ended a wait-for-event sleep, must sleep, which shows that the wake left the latch clear.

// File: rtl/slp_pkg.sv
package slp_pkg;

    // Power state of the controller
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,  // core executing
        ST_NAP  = 2'd1,  // core clock gated only
        ST_DEEP = 2'd2,  // system clock gated, PLL and flash powered down
        ST_WAKE = 2'd3   // power restored, system clock still gated
    } slp_state_e;

endpackage

// File: rtl/slp_evt_latch.sv
module slp_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,      // send-event or external event this cycle
    input  logic consume_i,  // a wait-for-event consumes the latch
    output logic evt_o
);

    logic evt_d, evt_q;

    // The set is applied first, then the consume, so a same-cycle pair ends clear
    always_comb begin
        evt_d = (evt_q | set_i) & ~consume_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_d;
    end

    assign evt_o = evt_q;

    AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !consume_i) |=> evt_q); // R5

    AST_LATCH_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |=> !evt_q); // R4

endmodule

// File: rtl/slp_power_fsm.sv
module slp_power_fsm
    import slp_pkg::*;
#(
    parameter int WAKE_GAP = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wfi_i,
    input  logic       wfe_i,
    input  logic       set_i,
    input  logic       evt_i,
    input  logic       irq_i,
    input  logic       dbg_i,
    input  logic       deep_i,
    output logic       consume_o,
    output slp_state_e st_o
);

    localparam int CW = (WAKE_GAP > 1) ? $clog2(WAKE_GAP) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(WAKE_GAP - 1);

    typedef struct packed {
        slp_state_e    st;
        logic          by_wfe;  // current sleep was entered by wait-for-event
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic wake;
    logic consume;

    always_comb begin
        fsm_d   = fsm_q;
        consume = 1'b0;
        wake    = irq_i | dbg_i | (fsm_q.by_wfe & set_i);
        unique case (fsm_q.st)
            ST_RUN: begin
                if (wfi_i) begin
                    fsm_d.st     = deep_i ? ST_DEEP : ST_NAP;
                    fsm_d.by_wfe = 1'b0;
                end else if (wfe_i) begin
                    consume = 1'b1;
                    if (!(evt_i | set_i)) begin
                        fsm_d.st     = deep_i ? ST_DEEP : ST_NAP;
                        fsm_d.by_wfe = 1'b1;
                    end
                end
            end
            ST_NAP, ST_DEEP: begin
                consume = fsm_q.by_wfe;
                if (wake) begin
                    fsm_d.st     = (fsm_q.st == ST_NAP) ? ST_RUN : ST_WAKE;
                    fsm_d.by_wfe = 1'b0;
                    fsm_d.cnt    = '0;
                end
            end
            ST_WAKE: begin
                if (fsm_q.cnt == CNT_LAST) fsm_d.st  = ST_RUN;
                else                       fsm_d.cnt = fsm_q.cnt + 1'b1;
            end
            default: fsm_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_RUN, by_wfe: 1'b0, cnt: '0};
        else        fsm_q <= fsm_d;
    end

    assign consume_o = consume;
    assign st_o      = fsm_q.st;

    AST_WFI_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_RUN && wfi_i) |=> (st_o != ST_RUN)); // R2

    AST_WFE_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_RUN && wfe_i && !wfi_i && (evt_i || set_i)) |=> (st_o == ST_RUN)); // R12

    AST_NAP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_NAP && (irq_i || dbg_i)) |=> (st_o == ST_RUN)); // R9

    AST_DEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_DEEP && !irq_i && !dbg_i && !set_i) |=> (st_o == ST_DEEP)); // R8

    AST_DEEP_EXIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == ST_RUN && $past(st_o) != ST_RUN) |-> ($past(st_o) != ST_DEEP)); // R10

endmodule

// File: rtl/slp_gate_decode.sv
module slp_gate_decode
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slp_state_e st_i,
    output logic       core_clk_en_o,
    output logic       sys_clk_en_o,
    output logic       pll_pd_o,
    output logic       flash_pd_o,
    output logic       stall_o
);

    always_comb begin
        core_clk_en_o = (st_i == ST_RUN);
        stall_o       = (st_i != ST_RUN);
        sys_clk_en_o  = (st_i == ST_RUN) || (st_i == ST_NAP);
        pll_pd_o      = (st_i == ST_DEEP);
        flash_pd_o    = (st_i == ST_DEEP);
    end

    AST_PD_NEEDS_SYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_pd_o || flash_pd_o) |-> (!sys_clk_en_o && stall_o)); // R7

    AST_SYS_BACK_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_pd_o) |-> !sys_clk_en_o); // R10

endmodule

// File: rtl/slp_evt_ctrl.sv
module slp_evt_ctrl
    import slp_pkg::*;
#(
    parameter int WAKE_GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_pulse,
    input  logic wfe_pulse,
    input  logic sev_pulse,
    input  logic ext_evt,
    input  logic irq_pend,
    input  logic dbg_req,
    input  logic deep_sel,
    output logic core_clk_en,
    output logic sys_clk_en,
    output logic pll_pd_req,
    output logic flash_pd_req,
    output logic core_stall
);

    logic       evt_set;
    logic       evt_now;
    logic       evt_consume;
    slp_state_e st;

    assign evt_set = sev_pulse | ext_evt;

    slp_evt_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (evt_set),
        .consume_i (evt_consume),
        .evt_o     (evt_now)
    );

    slp_power_fsm #(.WAKE_GAP(WAKE_GAP)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfi_i     (wfi_pulse),
        .wfe_i     (wfe_pulse),
        .set_i     (evt_set),
        .evt_i     (evt_now),
        .irq_i     (irq_pend),
        .dbg_i     (dbg_req),
        .deep_i    (deep_sel),
        .consume_o (evt_consume),
        .st_o      (st)
    );

    slp_gate_decode u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .st_i          (st),
        .core_clk_en_o (core_clk_en),
        .sys_clk_en_o  (sys_clk_en),
        .pll_pd_o      (pll_pd_req),
        .flash_pd_o    (flash_pd_req),
        .stall_o       (core_stall)
    );

    AST_STALL_WITH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall == !core_clk_en); // R6

endmodule

// File: tb/slp_evt_ctrl_tb.sv
`timescale 1ns/1ps
module slp_evt_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_pulse = 0, wfe_pulse = 0, sev_pulse = 0, ext_evt = 0;
    logic irq_pend = 0, dbg_req = 0, deep_sel = 0;
    logic core_clk_en, sys_clk_en, pll_pd_req, flash_pd_req, core_stall;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    slp_evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .wfi_pulse(wfi_pulse), .wfe_pulse(wfe_pulse), .sev_pulse(sev_pulse),
        .ext_evt(ext_evt), .irq_pend(irq_pend), .dbg_req(dbg_req), .deep_sel(deep_sel),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .pll_pd_req(pll_pd_req),
        .flash_pd_req(flash_pd_req), .core_stall(core_stall)
    );

    // Output pattern {core_clk_en, sys_clk_en, pll_pd_req, flash_pd_req, core_stall}
    localparam logic [4:0] O_RUN  = 5'b11000;
    localparam logic [4:0] O_NAP  = 5'b01001;
    localparam logic [4:0] O_DEEP = 5'b00111;
    localparam logic [4:0] O_WAKE = 5'b00001;

    // Vector: {wfi, wfe, sev, ext, irq, dbg, deep} , expected outputs , requirement number
    localparam int NV = 30;
    localparam logic [15:0] VECS [0:NV-1] = '{
        {7'b0000000, O_RUN,  4'd1 },  // R1 idle after reset
        {7'b1000000, O_NAP,  4'd6 },  // R2 R6 light sleep
        {7'b0000001, O_NAP,  4'd8 },  // R8 select changes during sleep
        {7'b0000100, O_RUN,  4'd9 },  // R9 interrupt wakes light sleep
        {7'b1000001, O_DEEP, 4'd7 },  // R7 deep sleep
        {7'b0000000, O_DEEP, 4'd8 },  // R8 select drops during deep sleep
        {7'b1000000, O_DEEP, 4'd13},  // R13 instruction while asleep
        {7'b0000010, O_WAKE, 4'd10},  // R10 debug wake, power-down released first
        {7'b0000000, O_RUN,  4'd10},  // R10 clocks back
        {7'b0010000, O_RUN,  4'd5 },  // R5 send-event sets latch
        {7'b0100000, O_RUN,  4'd4 },  // R4 latch set, no sleep
        {7'b0100000, O_NAP,  4'd3 },  // R3 latch now clear, sleeps
        {7'b0001000, O_RUN,  4'd11},  // R11 external event wakes
        {7'b0100000, O_NAP,  4'd11},  // R11 latch left clear by wake
        {7'b0000010, O_RUN,  4'd9 },  // R9 debug wakes, re-entry next
        {7'b0110000, O_RUN,  4'd12},  // R12 same-cycle pair
        {7'b0100000, O_NAP,  4'd12},  // R12 latch ended clear
        {7'b0000100, O_RUN,  4'd9 },  // R9
        {7'b0001000, O_RUN,  4'd5 },  // R5 external event sets latch
        {7'b1000000, O_NAP,  4'd2 },  // R2 sleeps despite set latch
        {7'b0000100, O_RUN,  4'd9 },  // R9
        {7'b0100000, O_RUN,  4'd4 },  // R4 latch still set
        {7'b1000001, O_DEEP, 4'd7 },  // R7
        {7'b0010001, O_DEEP, 4'd11},  // R11 event does not wake a wfi sleep
        {7'b0000101, O_WAKE, 4'd10},  // R10 interrupt wake from deep
        {7'b0000001, O_RUN,  4'd10},  // R10
        {7'b0100001, O_RUN,  4'd11},  // R11 latch was set during sleep
        {7'b0100001, O_DEEP, 4'd3 },  // R3 deep sleep by wait-for-event
        {7'b0001001, O_WAKE, 4'd11},  // R11 event wakes deep wfe sleep
        {7'b0000000, O_RUN,  4'd10}   // R10
    };

    function automatic logic [4:0] outs();
        return {core_clk_en, sys_clk_en, pll_pd_req, flash_pd_req, core_stall};
    endfunction

    task automatic chk(input logic [4:0] exp, input int req, input string what);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %b expected %b", req, what, outs(), exp);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        {wfi_pulse, wfe_pulse, sev_pulse, ext_evt, irq_pend, dbg_req, deep_sel} = v;
    endtask

    // Apply inputs for one edge, then sample just after it
    task automatic step(input logic [6:0] v);
        drive(v);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        chk(O_RUN, 1, "during reset");            // R1
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][15:9]);
            chk(VECS[i][8:4], int'(VECS[i][3:0]), $sformatf("vector %0d", i));
        end

        // R3: latch left clear after the last vector
        step(7'b0100000); chk(O_NAP, 3, "wfe after event wake");
        step(7'b0000100); chk(O_RUN, 9, "irq wake");

        // R1: reset in the middle of deep sleep clears latch and state
        step(7'b0010000); chk(O_RUN, 5, "set latch before reset");
        step(7'b1000001); chk(O_DEEP, 7, "deep before reset");
        drive(7'b0000000);
        rst_n = 1'b0;
        #1 chk(O_RUN, 1, "async reset in sleep");
        @(posedge clk); #1;
        rst_n = 1'b1;
        step(7'b0100000); chk(O_NAP, 1, "latch cleared by reset");
        step(7'b0000010); chk(O_RUN, 9, "debug wake");

        // R13: wait-for-event pulse during a wfi sleep is ignored
        step(7'b1000000); chk(O_NAP, 13, "wfi sleep");
        step(7'b0100000); chk(O_NAP, 13, "wfe ignored while asleep");
        step(7'b0000100); chk(O_RUN, 9, "irq wake");

        // R2 with R9: wfi while an interrupt is already pending
        step(7'b1000100); chk(O_NAP, 2, "wfi with irq pending");
        step(7'b0000100); chk(O_RUN, 9, "immediate wake");
        step(7'b0000000); chk(O_RUN, 9, "stays running");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule